// File: doc/BRIEF.md
# SD Host Command Status and Interrupt Unit

This block holds the event status, interrupt masking and control strobes of an SD/MMC host command path. Single-cycle event pulses from the command engine, the data engine and the card-detect logic are caught in two byte-wide status registers. Software clears a bit by writing a 1 to it. Two byte-wide mask registers and one global enable bit turn the caught events into a single level interrupt.

The unit also reports live pin levels: write protect, the data-line-3 detect level, the dedicated detect pin level, and a card-present level. The card-present level comes from whichever detect source is selected, after optional inversion. Any change of that corrected level is also caught as an insertion event. Writing the control register can raise a command-start strobe and a response-FIFO-reset strobe. Each lasts one cycle and is never stored. The command type and the block size are held for the card-bus engines.

Top module: `sdc_status_irq`

## Requirements
- R1: After reset every register (control, block length low/high, both masks, both status bytes) reads 0, both strobes are low and `irq_o` is low, provided all pins are low.
- R2: A 1 on any bit of `rsp_evt_i` sets the same bit of status byte 1 (address 6). The bit stays set until a write to address 6 has a 1 in that position. Writing 0 to a bit leaves it unchanged.
- R3: In status byte 0 (address 5), bit 5 latches `blk_done_i` and bit 4 latches `mblk_done_i`, and both are cleared by writing 1. Bits 1 (write protect), 2 (data line 3 level), 3 (detect pin level) and 6 (corrected card level) show the synchronised live levels and cannot be cleared by a write. Bit 0 reads 0.
- R4: If an event arrives in the same cycle as a write of 1 to clear that status bit, the bit stays set.
- R5: Bit 7 of status byte 0 is set on every change of the corrected card level, for both insertion and removal. A pin change shows in the live bits after `SYNC_STAGES` clocks, and the insertion bit is set one clock after that.
- R6: In block length high (address 2), bit 5 selects the detect source (1 = detect pin, 0 = data line 3), and bit 4 inverts the selected level before it is reported and before changes are detected.
- R7: `irq_o` is high while some latched status bit has its mask bit set. Mask 0 (address 3) holds only bits 7:4, and mask 1 (address 4) holds only bits 7:1, so the bit 0 event of status byte 1 never raises the interrupt.
- R8: Bit 7 of block length high is a global interrupt enable. While it is 0, `irq_o` is low whatever the status and masks hold.
- R9: In the control register (address 0), writing 1 to bit 0 pulses `cmd_start_o`, and writing 1 to bit 3 pulses `fifo_rst_o`. Each pulse is high for exactly the one clock after the write, and both bits read back 0. Bits 7:4 (command type, on `cmd_type_o`) and bits 2:1 are stored.
- R10: `blk_size_m1_o` is bits 2:0 of block length high followed by block length low (address 1).
- R11: Reads are combinational on `rd_addr_i` over addresses 0 to 6. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data |
| rsp_evt_i | input | 8 | Event pulses for status byte 1 |
| blk_done_i | input | 1 | Block-done event pulse |
| mblk_done_i | input | 1 | Multi-block-done event pulse |
| cd_pin_i | input | 1 | Asynchronous card-detect pin |
| cd_dat3_i | input | 1 | Asynchronous data line 3 detect level |
| wp_pin_i | input | 1 | Asynchronous write-protect pin |
| cmd_start_o | output | 1 | One-cycle command start strobe |
| fifo_rst_o | output | 1 | One-cycle response FIFO reset strobe |
| cmd_type_o | output | 4 | Stored command type |
| blk_size_m1_o | output | 11 | Block size minus one |
| irq_o | output | 1 | Interrupt request |

## Verification
The sharpest collision is an event pulse and a write-one-to-clear that hit the same status bit in one clock. The bench forces this on purpose: it raises an event bit while writing a 1 to that bit, and also while writing a 1 to a neighbouring bit. The bench then reads the status byte back and expects the pulsed bit still set and only the targeted neighbour cleared. A second overlap occurs when a write to the polarity or source bits lands while a detect change is still in the synchroniser. Random phases drive both overlaps many times. A behavioural model checks every output on every clock.

// File: rtl/sdc_stat_pkg.sv
package sdc_stat_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_BLK_LO = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BLK_HI = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MASK0  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MASK1  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STAT0  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STAT1  = 3'd6;

  // control strobe positions and block-length-high option bits
  localparam int CTRL_START = 0;
  localparam int CTRL_FRST  = 3;
  localparam int HI_IEN     = 7;
  localparam int HI_SRC_PIN = 5;
  localparam int HI_INV     = 4;

  // status byte 0 bit positions
  localparam int S0_WP   = 1;
  localparam int S0_DAT3 = 2;
  localparam int S0_PIN  = 3;
  localparam int S0_MBLK = 4;
  localparam int S0_BLK  = 5;
  localparam int S0_CD   = 6;
  localparam int S0_INS  = 7;

  localparam logic [7:0] CTRL_KEEP   = 8'hF6;
  localparam logic [7:0] MASK0_KEEP  = 8'hF0;
  localparam logic [7:0] MASK1_KEEP  = 8'hFE;
  localparam logic [7:0] STAT0_LATCH = 8'hB0;
  localparam logic [7:0] STAT1_LATCH = 8'hFF;

  typedef struct packed {
    logic wp;
    logic dat3;
    logic pin;
  } pin_set_t;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d_i;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdc_w1c_bank.sv
module sdc_w1c_bank #(
  parameter int           W          = 8,
  parameter logic [W-1:0] LATCH_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (LATCH_MASK[b]) begin : g_lat
      logic bit_d, bit_q, bit_ce;
      always_comb begin
        bit_ce = set_i[b] | clr_en_i;
        bit_d  = bit_q;
        if (clr_en_i && clr_bits_i[b]) bit_d = 1'b0;
        if (set_i[b])                  bit_d = 1'b1;  // set beats clear
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_ce) bit_q <= bit_d;
      end
      assign q_o[b] = bit_q;
    end else begin : g_tie
      logic unused_in;
      assign unused_in = set_i[b] ^ clr_bits_i[b];
      assign q_o[b]    = 1'b0;
    end
  end
endmodule

// File: rtl/sdc_detect.sv
module sdc_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic dat3_s_i,
  input  logic src_pin_i,
  input  logic invert_i,
  output logic level_o,
  output logic change_o
);
  logic lvl, seen_q;

  always_comb begin
    lvl      = (src_pin_i ? pin_s_i : dat3_s_i) ^ invert_i;
    change_o = lvl ^ seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= lvl;
  end

  assign level_o = lvl;
endmodule

// File: rtl/sdc_cfg_regs.sv
module sdc_cfg_regs
  import sdc_stat_pkg::*;
#(
  parameter int BLK_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        blk_lo_o,
  output logic [7:0]        blk_hi_o,
  output logic [7:0]        mask0_o,
  output logic [7:0]        mask1_o,
  output logic              start_o,
  output logic              frst_o,
  output logic [BLK_W-1:0]  blk_size_m1_o
);
  localparam int HI_W = BLK_W - 8;

  logic [7:0] ctrl_q, lo_q, hi_q, m0_q, m1_q;
  logic [7:0] ctrl_d, m0_d, m1_d;
  logic       start_q, frst_q, start_d, frst_d;
  logic       we_ctrl, we_lo, we_hi, we_m0, we_m1;

  always_comb begin
    we_ctrl = wr_en_i && (wr_addr_i == ADR_CTRL);
    we_lo   = wr_en_i && (wr_addr_i == ADR_BLK_LO);
    we_hi   = wr_en_i && (wr_addr_i == ADR_BLK_HI);
    we_m0   = wr_en_i && (wr_addr_i == ADR_MASK0);
    we_m1   = wr_en_i && (wr_addr_i == ADR_MASK1);
    ctrl_d  = wr_data_i & CTRL_KEEP;
    m0_d    = wr_data_i & MASK0_KEEP;
    m1_d    = wr_data_i & MASK1_KEEP;
    start_d = we_ctrl & wr_data_i[CTRL_START];
    frst_d  = we_ctrl & wr_data_i[CTRL_FRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      m0_q    <= '0;
      m1_q    <= '0;
      start_q <= 1'b0;
      frst_q  <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_q <= ctrl_d;
      if (we_lo)   lo_q   <= wr_data_i;
      if (we_hi)   hi_q   <= wr_data_i;
      if (we_m0)   m0_q   <= m0_d;
      if (we_m1)   m1_q   <= m1_d;
      start_q <= start_d;
      frst_q  <= frst_d;
    end
  end

  assign ctrl_o        = ctrl_q;
  assign blk_lo_o      = lo_q;
  assign blk_hi_o      = hi_q;
  assign mask0_o       = m0_q;
  assign mask1_o       = m1_q;
  assign start_o       = start_q;
  assign frst_o        = frst_q;
  assign blk_size_m1_o = {hi_q[HI_W-1:0], lo_q};
endmodule

// File: rtl/sdc_status_irq.sv
module sdc_status_irq
  import sdc_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BLK_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic [7:0]        rsp_evt_i,
  input  logic              blk_done_i,
  input  logic              mblk_done_i,
  input  logic              cd_pin_i,
  input  logic              cd_dat3_i,
  input  logic              wp_pin_i,
  output logic              cmd_start_o,
  output logic              fifo_rst_o,
  output logic [3:0]        cmd_type_o,
  output logic [BLK_W-1:0]  blk_size_m1_o,
  output logic              irq_o
);
  logic [7:0] ctrl_q, blk_lo_q, blk_hi_q, mask0_q, mask1_q;
  logic [7:0] st0_lat, st1_q, st0_set, st0_view;
  logic       clr0_en, clr1_en, cd_level, cd_change, irq_en;
  pin_set_t   pins_raw, pins_s;

  sdc_cfg_regs #(.BLK_W(BLK_W)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .ctrl_o        (ctrl_q),
    .blk_lo_o      (blk_lo_q),
    .blk_hi_o      (blk_hi_q),
    .mask0_o       (mask0_q),
    .mask1_o       (mask1_q),
    .start_o       (cmd_start_o),
    .frst_o        (fifo_rst_o),
    .blk_size_m1_o (blk_size_m1_o)
  );

  assign pins_raw = '{wp: wp_pin_i, dat3: cd_dat3_i, pin: cd_pin_i};

  sdc_sync #(.W($bits(pin_set_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  sdc_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_s_i   (pins_s.pin),
    .dat3_s_i  (pins_s.dat3),
    .src_pin_i (blk_hi_q[HI_SRC_PIN]),
    .invert_i  (blk_hi_q[HI_INV]),
    .level_o   (cd_level),
    .change_o  (cd_change)
  );

  always_comb begin
    st0_set          = '0;
    st0_set[S0_INS]  = cd_change;
    st0_set[S0_BLK]  = blk_done_i;
    st0_set[S0_MBLK] = mblk_done_i;
    clr0_en          = wr_en_i && (wr_addr_i == ADR_STAT0);
    clr1_en          = wr_en_i && (wr_addr_i == ADR_STAT1);
  end

  sdc_w1c_bank #(.W(8), .LATCH_MASK(STAT0_LATCH)) u_st0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (st0_set),
    .clr_en_i   (clr0_en),
    .clr_bits_i (wr_data_i),
    .q_o        (st0_lat)
  );

  sdc_w1c_bank #(.W(8), .LATCH_MASK(STAT1_LATCH)) u_st1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (rsp_evt_i),
    .clr_en_i   (clr1_en),
    .clr_bits_i (wr_data_i),
    .q_o        (st1_q)
  );

  always_comb begin
    st0_view          = st0_lat;
    st0_view[S0_WP]   = pins_s.wp;
    st0_view[S0_DAT3] = pins_s.dat3;
    st0_view[S0_PIN]  = pins_s.pin;
    st0_view[S0_CD]   = cd_level;
  end

  assign irq_en     = blk_hi_q[HI_IEN];
  assign irq_o      = irq_en & ((|(st0_lat & mask0_q)) | (|(st1_q & mask1_q)));
  assign cmd_type_o = ctrl_q[7:4];

  always_comb begin
    case (rd_addr_i)
      ADR_CTRL:   rd_data_o = ctrl_q;
      ADR_BLK_LO: rd_data_o = blk_lo_q;
      ADR_BLK_HI: rd_data_o = blk_hi_q;
      ADR_MASK0:  rd_data_o = mask0_q;
      ADR_MASK1:  rd_data_o = mask1_q;
      ADR_STAT0:  rd_data_o = st0_view;
      ADR_STAT1:  rd_data_o = st1_q;
      default:    rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/sdc_status_irq_chk.sv
module sdc_status_irq_chk
  import sdc_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic [7:0]        rsp_evt_i,
  input logic              cmd_start_o,
  input logic              fifo_rst_o,
  input logic              irq_o,
  input logic [7:0]        st0_q,
  input logic [7:0]        st1_q,
  input logic [7:0]        mask0_q,
  input logic [7:0]        mask1_q,
  input logic              irq_en
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_start_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cmd_start_o) |-> $past(wr_en_i && (wr_addr_i == ADR_CTRL) && wr_data_i[CTRL_START]));

  assert_frst_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fifo_rst_o) |-> $past(wr_en_i && (wr_addr_i == ADR_CTRL) && wr_data_i[CTRL_FRST]));

  assert_strobes_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == ADR_CTRL) |-> (rd_data_o[CTRL_START] == 1'b0 && rd_data_o[CTRL_FRST] == 1'b0));

  assert_event_caught_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((st1_q & $past(rsp_evt_i)) == $past(rsp_evt_i)));

  assert_status_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(wr_en_i && (wr_addr_i == ADR_STAT1))) |-> ((st1_q & $past(st1_q)) == $past(st1_q)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en);

  assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((st0_q & mask0_q) != 8'h00) || ((st1_q & mask1_q) != 8'h00)));
endmodule

bind sdc_status_irq sdc_status_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .rsp_evt_i   (rsp_evt_i),
  .cmd_start_o (cmd_start_o),
  .fifo_rst_o  (fifo_rst_o),
  .irq_o       (irq_o),
  .st0_q       (st0_lat),
  .st1_q       (st1_q),
  .mask0_q     (mask0_q),
  .mask1_q     (mask1_q),
  .irq_en      (irq_en)
);

// File: tb/sdc_status_irq_test.sv
module sdc_status_irq_test;
  import sdc_stat_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [7:0]  rsp_evt_i = '0;
  logic        blk_done_i = 1'b0, mblk_done_i = 1'b0;
  logic        cd_pin_i = 1'b0, cd_dat3_i = 1'b0, wp_pin_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        cmd_start_o, fifo_rst_o, irq_o;
  logic [3:0]  cmd_type_o;
  logic [10:0] blk_size_m1_o;

  always #10 clk = ~clk;

  sdc_status_irq uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .rsp_evt_i(rsp_evt_i), .blk_done_i(blk_done_i), .mblk_done_i(mblk_done_i),
    .cd_pin_i(cd_pin_i), .cd_dat3_i(cd_dat3_i), .wp_pin_i(wp_pin_i),
    .cmd_start_o(cmd_start_o), .fifo_rst_o(fifo_rst_o), .cmd_type_o(cmd_type_o),
    .blk_size_m1_o(blk_size_m1_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit model_on = 1'b0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_ctrl = 0, m_lo = 0, m_hi = 0, m_m0 = 0, m_m1 = 0, m_s0 = 0, m_s1 = 0;
  logic       m_det = 0, m_start = 0, m_frst = 0;
  logic [2:0] m_sq[$];   // {wp,dat3,pin}; front = synchronised output

  function automatic logic m_level();
    logic [2:0] s = m_sq[0];
    logic sel = m_hi[5] ? s[0] : s[1];
    return sel ^ m_hi[4];
  endfunction

  function automatic logic m_irq();
    return m_hi[7] && (((m_s0 & m_m0) | (m_s1 & m_m1)) != 8'h00);
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    logic [2:0] s = m_sq[0];
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_lo;
      3'd2: return m_hi;
      3'd3: return m_m0;
      3'd4: return m_m1;
      3'd5: return m_s0 | {1'b0, m_level(), 2'b00, s[0], s[1], s[2], 1'b0};
      3'd6: return m_s1;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_lo = 0; m_hi = 0; m_m0 = 0; m_m1 = 0; m_s0 = 0; m_s1 = 0;
      m_det = 0; m_start = 0; m_frst = 0;
      m_sq = '{3'b000, 3'b000};
      model_on = 1'b1;
    end else begin
      logic lvl, ins;
      logic [7:0] c0, c1;
      lvl = m_level();
      ins = (lvl != m_det);
      c0 = (wr_en_i && wr_addr_i == 3'd5) ? wr_data_i : 8'h00;
      c1 = (wr_en_i && wr_addr_i == 3'd6) ? wr_data_i : 8'h00;
      m_s0 = ((m_s0 & ~c0) | {ins, 1'b0, blk_done_i, mblk_done_i, 4'b0000}) & 8'hB0;
      m_s1 = (m_s1 & ~c1) | rsp_evt_i;
      m_det = lvl;
      m_start = wr_en_i && wr_addr_i == 3'd0 && wr_data_i[0];
      m_frst  = wr_en_i && wr_addr_i == 3'd0 && wr_data_i[3];
      if (wr_en_i) begin
        case (wr_addr_i)
          3'd0: m_ctrl = wr_data_i & 8'hF6;
          3'd1: m_lo   = wr_data_i;
          3'd2: m_hi   = wr_data_i;
          3'd3: m_m0   = wr_data_i & 8'hF0;
          3'd4: m_m1   = wr_data_i & 8'hFE;
          default: ;
        endcase
      end
      void'(m_sq.pop_front());
      m_sq.push_back({wp_pin_i, cd_dat3_i, cd_pin_i});
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R7 irq_o vs model", irq_o, m_irq());
      check("R9 cmd_start_o vs model", cmd_start_o, m_start);
      check("R9 fifo_rst_o vs model", fifo_rst_o, m_frst);
      check("R9 cmd_type_o vs model", cmd_type_o, m_ctrl[7:4]);
      check("R10 blk_size_m1_o vs model", blk_size_m1_o, {m_hi[2:0], m_lo});
      check("R11 rd_data_o vs model", rd_data_o, m_read(rd_addr_i));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(bit we, logic [2:0] a, logic [7:0] d, logic [7:0] ev, bit b, bit mb);
    @(posedge clk); #2;
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    rsp_evt_i = ev; blk_done_i = b; mblk_done_i = mb;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 3'd0, 8'h00, 8'h00, 0, 0);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    step(1, a, d, 8'h00, 0, 0);
  endtask

  task automatic rd_chk(logic [2:0] a, logic [7:0] exp, string req);
    idle(1);
    rd_addr_i = a;
    @(negedge clk);
    check(req, rd_data_o, exp);
  endtask

  task automatic irq_chk(bit exp, string req);
    idle(1);
    @(negedge clk);
    check(req, irq_o, exp);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    check("R1 irq_o in reset", irq_o, 0);
    check("R1 rd_data_o in reset", rd_data_o, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'h00, "R1 register after reset");

    // R10 / R11
    wr(ADR_BLK_LO, 8'hFF);
    wr(ADR_BLK_HI, 8'h03);
    idle(1); @(negedge clk);
    check("R10 block size", blk_size_m1_o, 11'h3FF);
    rd_chk(3'd2, 8'h03, "R11 block high readback");
    rd_chk(3'd7, 8'h00, "R11 unused address");

    // R9 self-clearing strobes
    wr(ADR_CTRL, 8'h29);
    idle(1); @(negedge clk);
    check("R9 start pulse high", cmd_start_o, 1);
    check("R9 fifo reset pulse high", fifo_rst_o, 1);
    check("R9 command type", cmd_type_o, 4'h2);
    idle(1); @(negedge clk);
    check("R9 start pulse cleared", cmd_start_o, 0);
    check("R9 fifo reset cleared", fifo_rst_o, 0);
    rd_chk(ADR_CTRL, 8'h20, "R9 strobe bits read zero");

    // R2 status byte 1
    step(0, 3'd0, 8'h00, 8'h16, 0, 0);
    rd_chk(ADR_STAT1, 8'h16, "R2 events latched");
    wr(ADR_STAT1, 8'h02);
    rd_chk(ADR_STAT1, 8'h14, "R2 write one clears");
    wr(ADR_STAT1, 8'h00);
    rd_chk(ADR_STAT1, 8'h14, "R2 write zero no effect");
    wr(ADR_STAT1, 8'hFF);
    rd_chk(ADR_STAT1, 8'h00, "R2 clear all");

    // R7 / R8 masking and global enable
    wr(ADR_MASK1, 8'hFF);
    rd_chk(ADR_MASK1, 8'hFE, "R7 mask1 writable bits");
    wr(ADR_BLK_HI, 8'h80);
    step(0, 3'd0, 8'h00, 8'h01, 0, 0);
    irq_chk(0, "R7 bit0 event cannot interrupt");
    step(0, 3'd0, 8'h00, 8'h04, 0, 0);
    irq_chk(1, "R7 masked event interrupts");
    wr(ADR_BLK_HI, 8'h00);
    irq_chk(0, "R8 global enable off");
    wr(ADR_BLK_HI, 8'h80);
    irq_chk(1, "R8 global enable on");
    wr(ADR_STAT1, 8'hFF);
    irq_chk(0, "R7 cleared status drops irq");

    // R4 set versus clear in one cycle
    step(0, 3'd0, 8'h00, 8'h08, 0, 0);
    step(1, ADR_STAT1, 8'h08, 8'h08, 0, 0);
    rd_chk(ADR_STAT1, 8'h08, "R4 set wins over clear");
    step(1, ADR_STAT1, 8'h08, 8'h10, 0, 0);
    rd_chk(ADR_STAT1, 8'h10, "R4 neighbour clear with event");
    wr(ADR_STAT1, 8'hFF);

    // R3 status byte 0
    step(0, 3'd0, 8'h00, 8'h00, 1, 1);
    rd_chk(ADR_STAT0, 8'h30, "R3 block events latched");
    wp_pin_i = 1'b1;
    idle(3);
    rd_chk(ADR_STAT0, 8'h32, "R3 write protect live");
    wr(ADR_STAT0, 8'hFF);
    rd_chk(ADR_STAT0, 8'h02, "R3 live bits survive clear");
    wr(ADR_MASK0, 8'hFF);
    rd_chk(ADR_MASK0, 8'hF0, "R7 mask0 writable bits");

    // R5 timing of detect through synchroniser
    idle(1);
    rd_addr_i = ADR_STAT0;
    cd_dat3_i = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R5 live level before insert latch", rd_data_o[7:6], 2'b01);
    check("R5 no irq before latch", irq_o, 0);
    @(negedge clk);
    check("R5 insert latched", rd_data_o[7:6], 2'b11);
    check("R5 insert raises irq", irq_o, 1);
    wr(ADR_STAT0, 8'hFF);
    rd_chk(ADR_STAT0, 8'h46, "R5 insert cleared, level stays");

    // R6 polarity and source select
    wr(ADR_BLK_HI, 8'h90);
    idle(2);
    rd_chk(ADR_STAT0, 8'h86, "R6 inverted level and change");
    wr(ADR_BLK_HI, 8'hB0);
    idle(2);
    wr(ADR_STAT0, 8'hFF);
    rd_chk(ADR_STAT0, 8'h46, "R6 pin source inverted");
    cd_pin_i = 1'b1;
    idle(4);
    rd_chk(ADR_STAT0, 8'h8E, "R5 removal also latched");
    wr(ADR_STAT0, 8'hFF);

    // random phase, checked against the model every clock
    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 2) == 0, 3'($urandom_range(0, 7)), 8'($urandom),
           ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00,
           $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
      rd_addr_i = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) cd_pin_i  = ~cd_pin_i;
      if ($urandom_range(0, 9) == 0) cd_dat3_i = ~cd_dat3_i;
      if ($urandom_range(0, 15) == 0) wp_pin_i = ~wp_pin_i;
    end
    idle(4);
    summary();
  end
endmodule